// File: doc/BRIEF.md
# Log-MAP Soft-In Soft-Out Trellis Decoder

This block decodes one block of a rate-1/2, four-state, non-systematic convolutional code in the log domain. It uses the forward/backward a posteriori algorithm with a corrected-max (max*) operator. For each trellis step it takes three soft values: the a priori log-likelihood ratio of the uncoded bit and the channel LLRs of the two code bits. For each step it returns extrinsic LLRs for all three bits. Those outputs can feed a later decoding stage or another soft decoder.

A block of `BLK_LEN` symbols is first loaded through a valid/ready handshake. The block then runs a backward recursion of one step per cycle and stores the backward state metrics. After that it runs a forward recursion of one step per cycle, and during that pass each extrinsic triple is presented with a valid strobe. The trellis connectivity is fixed wiring, not a table. State metrics are kept bounded by subtracting a fixed constant.

Top module: `logmap_siso`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: In the load phase `in_ready` is 1 and `out_valid` is 0. A symbol is taken on each clock edge where `in_valid` and `in_ready` are both 1. After `BLK_LEN` symbols, `in_ready` drops to 0.
- R3: States are indexed s = 2*s1 + s0. Input bit u moves the trellis from state s to state 2*u + s1. The two code bits on that edge are a = u^s1^s0 and b = u^s0. Edge index e = 2*s + u. The branch metric is the sum of the LLRs (u: a priori, a, b: channel) of every bit that is 1 on the edge.
- R4: max*(x,y) = max(x,y) + c. Here c = 5 if |x-y| < 4, c = 3 if |x-y| < 12, c = 1 if |x-y| < 24, and c = 0 otherwise (LSB = 1/8).
- R5: Each recursion step forms raw metrics with max* over the two incoming (forward) or outgoing (backward) edges. If any raw metric is at least 2^(MET_W-3), that constant is subtracted from all four. Each result is then clamped from below at -2^(MET_W-2).
- R6: The forward metrics start as 0 for state 0 and -2^(MET_W-2) for the others. With `TERMINATED`=1 the backward metrics at step `BLK_LEN` start the same way. With `TERMINATED`=0 they all start at 0.
- R7: The uncoded extrinsic at step k is M1 - M0. Mb is formed as follows: take the edges with u=b in increasing e. For each edge take the value alpha_k[s] + beta_{k+1}[next] + the channel LLRs of its code bits that are 1. Combine the four values as max*(max*(v0,v1), max*(v2,v3)). The a priori LLR of u is excluded.
- R8: The extrinsic for code bit a (and likewise for b) uses the same form, over edges grouped by that bit. Each edge value includes the u contribution and the other code bit's contribution, and excludes its own LLR.
- R9: Extrinsic outputs saturate to the symmetric range [-(2^(EXT_W-1)-1), 2^(EXT_W-1)-1].
- R10: Exactly `BLK_LEN` output triples are strobed per block, in forward order from step 0. After them the block returns to the load phase.
- R11: `in_valid` and the input LLRs have no effect while `in_ready` is 0. The outputs depend only on the symbols that were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block accepts a symbol (load phase) |
| in_llr_u | input | LLR_W | A priori LLR of the uncoded bit, signed |
| in_llr_a | input | LLR_W | Channel LLR of code bit a, signed |
| in_llr_b | input | LLR_W | Channel LLR of code bit b, signed |
| out_valid | output | 1 | Extrinsic triple valid |
| out_ext_u | output | EXT_W | Extrinsic LLR of the uncoded bit |
| out_ext_a | output | EXT_W | Extrinsic LLR of code bit a |
| out_ext_b | output | EXT_W | Extrinsic LLR of code bit b |

## Verification
The bench builds the decoder with `BLK_LEN`=6 and the default widths (7-bit LLRs, 12-bit metrics, termination on). Six steps keep a full block small enough to replay in an integer model, yet at full-scale LLRs the metrics cross the subtraction threshold within three steps, so normalisation and clamping at the floor are both exercised. Blocks with all-zero, all-maximum, all-minimum, single-spike and pseudo-random LLRs cover saturation of the extrinsics, the correction steps of max* and the terminated start.

// File: rtl/logmap_pkg.sv
package logmap_pkg;
  localparam int NSTATE = 4;
  localparam int NEDGE  = 8;

  typedef enum logic [1:0] {PH_LOAD, PH_BWD, PH_FWD} phase_e;

  // bit selector: 0 = uncoded u, 1 = code bit a, 2 = code bit b; edge e = 2*s + u
  function automatic logic edge_bit(input int sel, input int e);
    logic u, s0, s1;
    u  = 1'(e & 1);
    s0 = 1'((e >> 1) & 1);
    s1 = 1'((e >> 2) & 1);
    case (sel)
      0:       return u;
      1:       return u ^ s1 ^ s0;
      default: return u ^ s0;
    endcase
  endfunction

  function automatic int succ(input int s, input int u);
    return 2 * u + (s >> 1);
  endfunction
endpackage

// File: rtl/logmap_maxstar.sv
module logmap_maxstar #(
  parameter int W = 14
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  logic signed [W:0] diff;
  logic        [W:0] mag;
  logic signed [W-1:0] big;
  logic        [2:0] corr;

  always_comb begin
    diff = {a[W-1], a} - {b[W-1], b};
    big  = diff[W] ? b : a;
    mag  = diff[W] ? (~diff + 1'b1) : diff;
    if (mag < 4)       corr = 3'd5;
    else if (mag < 12) corr = 3'd3;
    else if (mag < 24) corr = 3'd1;
    else               corr = 3'd0;
    y = big + $signed({{(W-3){1'b0}}, corr});
  end
endmodule

// File: rtl/logmap_step.sv
module logmap_step
  import logmap_pkg::*;
#(
  parameter int MET_W    = 12,
  parameter int LLR_W    = 7,
  parameter bit BACKWARD = 1'b0
) (
  input  logic signed [MET_W-1:0] met_in  [NSTATE],
  input  logic signed [LLR_W-1:0] lu,
  input  logic signed [LLR_W-1:0] la,
  input  logic signed [LLR_W-1:0] lb,
  output logic signed [MET_W-1:0] met_out [NSTATE]
);
  localparam int CW = MET_W + 2;
  localparam logic signed [CW-1:0] THR   = CW'(1 << (MET_W - 3));
  localparam logic signed [CW-1:0] FLOOR = -CW'(1 << (MET_W - 2));

  logic signed [CW-1:0] cand0 [NSTATE];
  logic signed [CW-1:0] cand1 [NSTATE];
  logic signed [CW-1:0] raw   [NSTATE];

  function automatic logic signed [CW-1:0] gam(input int e, input logic signed [LLR_W-1:0] gu,
                                              input logic signed [LLR_W-1:0] ga,
                                              input logic signed [LLR_W-1:0] gb);
    logic signed [CW-1:0] g;
    g = '0;
    if (edge_bit(0, e)) g = g + CW'(gu);
    if (edge_bit(1, e)) g = g + CW'(ga);
    if (edge_bit(2, e)) g = g + CW'(gb);
    return g;
  endfunction

  for (genvar i = 0; i < NSTATE; i++) begin : g_state
    if (!BACKWARD) begin : g_fwd
      // predecessors of state i: s1 = i[0], u = i[1]
      localparam int P0 = 2 * (i & 1);
      localparam int P1 = 2 * (i & 1) + 1;
      localparam int U  = i >> 1;
      assign cand0[i] = CW'(met_in[P0]) + gam(2 * P0 + U, lu, la, lb);
      assign cand1[i] = CW'(met_in[P1]) + gam(2 * P1 + U, lu, la, lb);
    end else begin : g_bwd
      assign cand0[i] = CW'(met_in[succ(i, 0)]) + gam(2 * i, lu, la, lb);
      assign cand1[i] = CW'(met_in[succ(i, 1)]) + gam(2 * i + 1, lu, la, lb);
    end
    logmap_maxstar #(.W(CW)) i_ms (.a(cand0[i]), .b(cand1[i]), .y(raw[i]));
  end

  always_comb begin
    logic over;
    logic signed [CW-1:0] t;
    over = 1'b0;
    for (int i = 0; i < NSTATE; i++) if (raw[i] >= THR) over = 1'b1;
    for (int i = 0; i < NSTATE; i++) begin
      t = over ? raw[i] - THR : raw[i];
      met_out[i] = (t < FLOOR) ? FLOOR[MET_W-1:0] : t[MET_W-1:0];
    end
  end
endmodule

// File: rtl/logmap_extr.sv
module logmap_extr
  import logmap_pkg::*;
#(
  parameter int MET_W = 12,
  parameter int LLR_W = 7,
  parameter int EXT_W = 7
) (
  input  logic signed [MET_W-1:0] alpha [NSTATE],
  input  logic signed [MET_W-1:0] beta  [NSTATE],
  input  logic signed [LLR_W-1:0] lu,
  input  logic signed [LLR_W-1:0] la,
  input  logic signed [LLR_W-1:0] lb,
  output logic signed [EXT_W-1:0] ext   [3]
);
  localparam int CW = MET_W + 2;
  localparam logic signed [CW:0] SATP = (CW+1)'((1 << (EXT_W - 1)) - 1);
  localparam logic signed [CW:0] SATN = -SATP;

  logic signed [LLR_W-1:0] lv [3];
  assign lv[0] = lu;
  assign lv[1] = la;
  assign lv[2] = lb;

  for (genvar x = 0; x < 3; x++) begin : g_bit
    logic signed [CW-1:0] val  [NEDGE];
    logic signed [CW-1:0] sel1 [4];
    logic signed [CW-1:0] sel0 [4];
    logic signed [CW-1:0] m1a, m1b, m1, m0a, m0b, m0;
    logic signed [CW:0]   diff;

    always_comb begin
      logic [2:0] k1, k0;
      for (int e = 0; e < NEDGE; e++) begin
        val[e] = CW'(alpha[e >> 1]) + CW'(beta[succ(e >> 1, e & 1)]);
        for (int y = 0; y < 3; y++)
          if (y != x && edge_bit(y, e)) val[e] = val[e] + CW'(lv[y]);
      end
      k1 = '0;
      k0 = '0;
      for (int j = 0; j < 4; j++) begin
        sel1[j] = '0;
        sel0[j] = '0;
      end
      for (int e = 0; e < NEDGE; e++) begin
        if (edge_bit(x, e)) begin
          sel1[k1[1:0]] = val[e];
          k1 = k1 + 3'd1;
        end else begin
          sel0[k0[1:0]] = val[e];
          k0 = k0 + 3'd1;
        end
      end
    end

    logmap_maxstar #(.W(CW)) i_m1a (.a(sel1[0]), .b(sel1[1]), .y(m1a));
    logmap_maxstar #(.W(CW)) i_m1b (.a(sel1[2]), .b(sel1[3]), .y(m1b));
    logmap_maxstar #(.W(CW)) i_m1  (.a(m1a),     .b(m1b),     .y(m1));
    logmap_maxstar #(.W(CW)) i_m0a (.a(sel0[0]), .b(sel0[1]), .y(m0a));
    logmap_maxstar #(.W(CW)) i_m0b (.a(sel0[2]), .b(sel0[3]), .y(m0b));
    logmap_maxstar #(.W(CW)) i_m0  (.a(m0a),     .b(m0b),     .y(m0));

    always_comb begin
      diff = {m1[CW-1], m1} - {m0[CW-1], m0};
      if (diff > SATP)      ext[x] = SATP[EXT_W-1:0];
      else if (diff < SATN) ext[x] = SATN[EXT_W-1:0];
      else                  ext[x] = diff[EXT_W-1:0];
    end
  end
endmodule

// File: rtl/logmap_siso.sv
module logmap_siso
  import logmap_pkg::*;
#(
  parameter int BLK_LEN    = 16,
  parameter int LLR_W      = 7,
  parameter int EXT_W      = 7,
  parameter int MET_W      = 12,
  parameter bit TERMINATED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [LLR_W-1:0] in_llr_u,
  input  logic signed [LLR_W-1:0] in_llr_a,
  input  logic signed [LLR_W-1:0] in_llr_b,
  output logic                    out_valid,
  output logic signed [EXT_W-1:0] out_ext_u,
  output logic signed [EXT_W-1:0] out_ext_a,
  output logic signed [EXT_W-1:0] out_ext_b
);
  localparam int AW = (BLK_LEN > 2) ? $clog2(BLK_LEN) : 1;
  localparam logic [AW-1:0] LAST = AW'(BLK_LEN - 1);
  localparam logic signed [MET_W-1:0] FLOOR = -MET_W'(1 << (MET_W - 2));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  assign rst_q = rsync[1];

  phase_e          phase, phase_n;
  logic [AW-1:0]   cnt, cnt_n;
  logic            llr_we, beta_we, alpha_ld, alpha_init, beta_ld, beta_init;

  logic signed [LLR_W-1:0] mem_u [BLK_LEN];
  logic signed [LLR_W-1:0] mem_a [BLK_LEN];
  logic signed [LLR_W-1:0] mem_b [BLK_LEN];
  logic signed [MET_W-1:0] beta_mem [BLK_LEN][NSTATE];

  logic signed [MET_W-1:0] alpha_r [NSTATE];
  logic signed [MET_W-1:0] beta_r  [NSTATE];
  logic signed [MET_W-1:0] fwd_nx  [NSTATE];
  logic signed [MET_W-1:0] bwd_nx  [NSTATE];
  logic signed [MET_W-1:0] beta_rd [NSTATE];
  logic signed [MET_W-1:0] a_init  [NSTATE];
  logic signed [MET_W-1:0] b_init  [NSTATE];
  logic signed [LLR_W-1:0] rd_u, rd_a, rd_b;
  logic signed [EXT_W-1:0] ext_v [3];

  for (genvar i = 0; i < NSTATE; i++) begin : g_init
    assign a_init[i] = (i == 0) ? '0 : FLOOR;
    assign b_init[i] = TERMINATED ? a_init[i] : '0;
  end

  assign rd_u = mem_u[cnt];
  assign rd_a = mem_a[cnt];
  assign rd_b = mem_b[cnt];
  always_comb for (int i = 0; i < NSTATE; i++) beta_rd[i] = beta_mem[cnt][i];

  always_comb begin
    phase_n    = phase;
    cnt_n      = cnt;
    llr_we     = 1'b0;
    beta_we    = 1'b0;
    beta_ld    = 1'b0;
    beta_init  = 1'b0;
    alpha_ld   = 1'b0;
    alpha_init = 1'b0;
    case (phase)
      PH_LOAD: if (in_valid) begin
        llr_we = 1'b1;
        if (cnt == LAST) begin
          phase_n   = PH_BWD;
          beta_init = 1'b1;
        end else cnt_n = cnt + 1'b1;
      end
      PH_BWD: begin
        beta_we = 1'b1;
        beta_ld = 1'b1;
        if (cnt == '0) begin
          phase_n    = PH_FWD;
          alpha_init = 1'b1;
        end else cnt_n = cnt - 1'b1;
      end
      PH_FWD: begin
        alpha_ld = 1'b1;
        if (cnt == LAST) begin
          phase_n = PH_LOAD;
          cnt_n   = '0;
        end else cnt_n = cnt + 1'b1;
      end
      default: phase_n = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q)
    if (!rst_q) begin
      phase <= PH_LOAD;
      cnt   <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
    end

  always_ff @(posedge clk) begin
    if (llr_we) begin
      mem_u[cnt] <= in_llr_u;
      mem_a[cnt] <= in_llr_a;
      mem_b[cnt] <= in_llr_b;
    end
    if (beta_we) for (int i = 0; i < NSTATE; i++) beta_mem[cnt][i] <= beta_r[i];
    if (beta_init)     beta_r  <= b_init;
    else if (beta_ld)  beta_r  <= bwd_nx;
    if (alpha_init)    alpha_r <= a_init;
    else if (alpha_ld) alpha_r <= fwd_nx;
  end

  logmap_step #(.MET_W(MET_W), .LLR_W(LLR_W), .BACKWARD(1'b1)) i_bwd (
    .met_in(beta_r), .lu(rd_u), .la(rd_a), .lb(rd_b), .met_out(bwd_nx));
  logmap_step #(.MET_W(MET_W), .LLR_W(LLR_W), .BACKWARD(1'b0)) i_fwd (
    .met_in(alpha_r), .lu(rd_u), .la(rd_a), .lb(rd_b), .met_out(fwd_nx));
  logmap_extr #(.MET_W(MET_W), .LLR_W(LLR_W), .EXT_W(EXT_W)) i_extr (
    .alpha(alpha_r), .beta(beta_rd), .lu(rd_u), .la(rd_a), .lb(rd_b), .ext(ext_v));

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_FWD);
  assign out_ext_u = ext_v[0];
  assign out_ext_a = ext_v[1];
  assign out_ext_b = ext_v[2];
endmodule

// File: rtl/logmap_siso_chk.sv
module logmap_siso_chk #(
  parameter int BLK_LEN = 16,
  parameter int EXT_W   = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic signed [EXT_W-1:0] out_ext_u,
  input logic signed [EXT_W-1:0] out_ext_a,
  input logic signed [EXT_W-1:0] out_ext_b
);
  localparam int CNW = $clog2(BLK_LEN + 1);
  localparam logic [EXT_W-1:0] MOST_NEG = {1'b1, {(EXT_W-1){1'b0}}};

  logic [CNW-1:0] ocnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         ocnt <= '0;
    else if (in_ready)  ocnt <= '0;
    else if (out_valid) ocnt <= ocnt + 1'b1;

  // R2: load and output phases never overlap
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R10: no more than one block of outputs per decode
  a_r10_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ocnt < CNW'(BLK_LEN)));
  // R10: the output burst ends with a full block and a return to loading
  a_r10_back_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (in_ready && ocnt == CNW'(BLK_LEN)));
  // R11: leaving the load phase starts the backward pass, not outputs
  a_r11_bwd_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> !out_valid);
  // R9: symmetric saturation never yields the most negative code
  a_r9_sym_sat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ext_u != MOST_NEG && out_ext_a != MOST_NEG && out_ext_b != MOST_NEG));
endmodule

bind logmap_siso logmap_siso_chk #(.BLK_LEN(BLK_LEN), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ext_u(out_ext_u), .out_ext_a(out_ext_a), .out_ext_b(out_ext_b));

// File: tb/test_logmap_siso.sv
module test_logmap_siso;
  localparam int N     = 6;
  localparam int MET_W = 12;
  localparam int THR   = 1 << (MET_W - 3);
  localparam int FLR   = -(1 << (MET_W - 2));
  localparam int SAT   = 63;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic signed [6:0] in_llr_u, in_llr_a, in_llr_b;
  logic out_valid;
  logic signed [6:0] out_ext_u, out_ext_a, out_ext_b;

  always #5 clk = ~clk;

  logmap_siso #(.BLK_LEN(N), .LLR_W(7), .EXT_W(7), .MET_W(MET_W), .TERMINATED(1'b1)) i_logmap_siso (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr_u(in_llr_u), .in_llr_a(in_llr_a), .in_llr_b(in_llr_b),
    .out_valid(out_valid), .out_ext_u(out_ext_u), .out_ext_a(out_ext_a), .out_ext_b(out_ext_b));

  int n_chk = 0;
  int n_bad = 0;
  int lu [N];
  int la [N];
  int lb [N];
  int exp_x [N][3];
  int seed = 32'h1234_5678;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ms(input int a, input int b);   // R4
    int d, c;
    d = (a > b) ? a - b : b - a;
    c = (d < 4) ? 5 : (d < 12) ? 3 : (d < 24) ? 1 : 0;
    return ((a > b) ? a : b) + c;
  endfunction

  function automatic int bitv(input int x, input int e);  // R3 edge bits
    int u, s0, s1;
    u = e % 2; s0 = (e / 2) % 2; s1 = e / 4;
    if (x == 0) return u;
    if (x == 1) return u ^ s1 ^ s0;
    return u ^ s0;
  endfunction

  function automatic int gam(input int e, input int k, input int skip);
    int g;
    g = 0;
    if (skip != 0 && bitv(0, e) == 1) g += lu[k];
    if (skip != 1 && bitv(1, e) == 1) g += la[k];
    if (skip != 2 && bitv(2, e) == 1) g += lb[k];
    return g;
  endfunction

  // R5 normalisation and floor
  task automatic norm(inout int m [4]);
    bit over;
    over = 0;
    for (int i = 0; i < 4; i++) if (m[i] >= THR) over = 1;
    for (int i = 0; i < 4; i++) begin
      if (over) m[i] -= THR;
      if (m[i] < FLR) m[i] = FLR;
    end
  endtask

  task automatic model();
    int al [4];
    int be [N+1][4];
    int nx [4];
    for (int i = 0; i < 4; i++) begin          // R6 terminated start
      be[N][i] = (i == 0) ? 0 : FLR;
      al[i]    = (i == 0) ? 0 : FLR;
    end
    for (int k = N - 1; k >= 0; k--) begin
      for (int s = 0; s < 4; s++)
        nx[s] = ms(gam(2*s, k, -1) + be[k+1][s/2], gam(2*s+1, k, -1) + be[k+1][2 + s/2]);
      norm(nx);
      for (int s = 0; s < 4; s++) be[k][s] = nx[s];
    end
    for (int k = 0; k < N; k++) begin
      for (int x = 0; x < 3; x++) begin         // R7 / R8
        int v1 [4];
        int v0 [4];
        int c1, c0, d;
        c1 = 0; c0 = 0;
        for (int e = 0; e < 8; e++) begin
          int v, s, u;
          s = e / 2; u = e % 2;
          v = al[s] + be[k+1][2*u + s/2] + gam(e, k, x);
          if (bitv(x, e) == 1) begin v1[c1] = v; c1++; end
          else begin v0[c0] = v; c0++; end
        end
        d = ms(ms(v1[0], v1[1]), ms(v1[2], v1[3])) - ms(ms(v0[0], v0[1]), ms(v0[2], v0[3]));
        if (d > SAT) d = SAT;                   // R9
        if (d < -SAT) d = -SAT;
        exp_x[k][x] = d;
      end
      for (int t = 0; t < 4; t++) begin
        int p0, p1, u;
        p0 = 2 * (t % 2); p1 = p0 + 1; u = t / 2;
        nx[t] = ms(al[p0] + gam(2*p0 + u, k, -1), al[p1] + gam(2*p1 + u, k, -1));
      end
      norm(nx);
      al = nx;
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 12) & 127) - 64;
  endfunction

  task automatic run_block(input string tag);
    int got, guard;
    bit ready_low_ok;
    model();
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check("R2 in_ready during load", int'(in_ready), 1);
      in_valid = 1'b1;
      in_llr_u = 7'(lu[k]); in_llr_a = 7'(la[k]); in_llr_b = 7'(lb[k]);
    end
    @(negedge clk);
    check("R2 in_ready after full block", int'(in_ready), 0);
    // R11: junk on the inputs while decoding
    in_llr_u = 7'sd63; in_llr_a = -7'sd64; in_llr_b = 7'sd17;
    got = 0; guard = 0; ready_low_ok = 1;
    while (got < N && guard < 4 * N + 10) begin
      if (in_ready) ready_low_ok = 0;
      if (out_valid) begin
        check({"R7 ext_u ", tag}, int'(out_ext_u), exp_x[got][0]);
        check({"R8 ext_a ", tag}, int'(out_ext_a), exp_x[got][1]);
        check({"R8 ext_b ", tag}, int'(out_ext_b), exp_x[got][2]);
        got++;
      end
      if (got == N) in_valid = 1'b0;
      else begin
        @(negedge clk);
        guard++;
      end
    end
    check("R10 output count", got, N);
    check("R11 in_ready low while decoding", int'(ready_low_ok), 1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 back to load ready", int'(in_ready), 1);
    check("R10 back to load no output", int'(out_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    in_llr_u = '0; in_llr_a = '0; in_llr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset in_ready", int'(in_ready), 1);
    check("R1 reset out_valid", int'(out_valid), 0);

    for (int k = 0; k < N; k++) begin lu[k] = 0;   la[k] = 0;   lb[k] = 0;   end
    run_block("zeros");
    for (int k = 0; k < N; k++) begin lu[k] = 63;  la[k] = 63;  lb[k] = 63;  end
    run_block("max R5");
    for (int k = 0; k < N; k++) begin lu[k] = -64; la[k] = -64; lb[k] = -64; end
    run_block("min R9");
    for (int k = 0; k < N; k++) begin lu[k] = 0; la[k] = (k == 2) ? 40 : -3; lb[k] = (k == 2) ? -40 : 2; end
    run_block("spike R3");
    for (int k = 0; k < N; k++) begin lu[k] = (k % 2) ? 1 : -1; la[k] = 2 * k - 5; lb[k] = 7 - 3 * k; end
    run_block("small R4");
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < N; k++) begin lu[k] = rnd(); la[k] = rnd(); lb[k] = rnd(); end
      run_block("random R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule